// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames in either an 8-bit format or a 9-bit multiprocessor format. A hardware comparator sits between the deframer and the sticky receive-complete flag. When filtering is active, only frames that carry a matching node address raise that flag, so a node on a shared bus is woken only by traffic meant for it. Firmware does not have to inspect every byte.

The serial line is oversampled by an external tick that pulses `OVS` times per bit period. Each bit is sampled at its midpoint. Two 8-bit inputs define the node address:

- an address value;
- a mask whose 1 bits mark the address positions that take part in the individual compare.

A second, broadcast pattern is formed by OR-ing the address and the mask. In it, a 1 bit demands a received 1 and a 0 bit is a don't-care. A received byte passes when it hits either the individual address or the broadcast pattern.

The mode select picks the frame format. Values with bit 1 set add a ninth bit, and a 1 in that bit marks an address frame. Value 0 is the shift-mode code: frames are received in the 8-bit format and the filter enable has no effect.

Top module: `addr_filter_uart_rx`

## Requirements
- R1: After reset, `rx_flag_o`, `rx_data_o` and `rx_bit9_o` are all 0.
- R2: A frame is a low start bit, then 8 data bits LSB first, then a ninth bit only when `mode_i[1]`=1, then a stop bit. At the end of every frame, `rx_data_o` takes the byte. `rx_bit9_o` takes the ninth bit in 9-bit modes and the stop-bit level in 8-bit modes. Both outputs hold their value between frames.
- R3: A start bit that reads high at its midpoint is discarded. No output changes, and the receiver then accepts the next frame normally.
- R4: With filtering inactive, a frame whose stop bit is 1 sets `rx_flag_o`. A frame whose stop bit is 0 never sets it, in any mode, although its data is still presented.
- R5: `rx_flag_o` stays 1 until `flag_clr_i` is sampled high in a cycle with no accepted frame. A frame acceptance takes priority over a clear in the same cycle.
- R6: In 9-bit modes with `filt_en_i`=1, a frame whose ninth bit is 0 never sets the flag. Its byte and ninth bit are still presented.
- R7: Individual match: the received byte equals `node_addr_i` in every bit position where `node_mask_i` is 1. Positions where the mask is 0 are ignored.
- R8: Broadcast match: every bit that is 1 in (`node_addr_i` OR `node_mask_i`) is received as 1.
- R9: With `mode_i`=0, `filt_en_i` has no effect, and any frame with a valid stop bit sets the flag.
- R10: With `node_addr_i`=0 and `node_mask_i`=0, every address frame passes the filter.
- R11: In mode 1 with `filt_en_i`=1, a matching byte sets the flag only if its stop bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | Oversampling tick, OVS pulses per bit |
| mode_i | input | 2 | 0 shift code (8-bit, no filter), 1 8-bit, 2/3 9-bit |
| filt_en_i | input | 1 | Address filter enable |
| node_addr_i | input | 8 | Node address |
| node_mask_i | input | 8 | Compare mask (1 = compared) |
| flag_clr_i | input | 1 | Clears the receive flag |
| rx_data_o | output | 8 | Last received byte |
| rx_bit9_o | output | 1 | Ninth bit (9-bit modes) or stop level (8-bit modes) |
| rx_flag_o | output | 1 | Sticky receive-complete flag |

## Verification
The bench uses an address of C0 with a mask of FD. It sends bytes that hit only the individual compare (C2), only the broadcast pattern (FF), and neither (C1). A design that swapped the roles of the address and the mask, or that treated a zero in the broadcast pattern as a required zero, would misclassify at least one of these bytes.

Data frames with a matching byte but a zero ninth bit must leave the flag low while still updating the data outputs. Frames with a bad stop bit must be rejected even when the byte matches.

A short low glitch on the line must change nothing, and the next frame must still be received. A design that sampled the start bit at its edge instead of its midpoint would lose that following frame. The shift-mode code must override the filter enable.

// File: rtl/afrx_pkg.sv
package afrx_pkg;
   parameter int unsigned BYTE_W = 8;
   localparam logic [1:0] MODE_SHIFT = 2'b00;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_NINTH,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic [BYTE_W-1:0] data;
      logic              b9;
      logic              stop;
   } rx_frame_t;
endpackage

// File: rtl/afrx_sync.sv
module afrx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) r <= 1'b1;
            else         r <= d_i;
         end
         assign q_o = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) r <= '1;
            else         r <= {r[STAGES-2:0], d_i};
         end
         assign q_o = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/afrx_deframer.sv
module afrx_deframer
   import afrx_pkg::*;
#(
   parameter int unsigned OVS = 16
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      tick_i,
   input  logic      rx_i,
   input  logic      nine_i,
   output rx_frame_t frm_o,
   output logic      frm_v_o
);
   localparam int unsigned CW = $clog2(OVS);
   localparam int unsigned IW = $clog2(BYTE_W);
   localparam logic [CW-1:0] HALF_LAST = CW'(OVS/2 - 1);
   localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
   localparam logic [IW-1:0] IDX_LAST  = IW'(BYTE_W - 1);

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     idx;
   logic [BYTE_W-1:0] sh;
   logic              b9;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         idx     <= '0;
         sh      <= '0;
         b9      <= 1'b0;
         frm_o   <= '0;
         frm_v_o <= 1'b0;
      end else begin
         frm_v_o <= 1'b0;
         if (tick_i) begin
            case (state)
               ST_IDLE: begin
                  if (!rx_i) begin
                     state <= ST_START;
                     cnt   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == HALF_LAST) begin
                     cnt   <= '0;
                     idx   <= '0;
                     state <= rx_i ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == FULL_LAST) begin
                     cnt <= '0;
                     sh  <= {rx_i, sh[BYTE_W-1:1]};
                     if (idx == IDX_LAST) state <= nine_i ? ST_NINTH : ST_STOP;
                     else                 idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_NINTH: begin
                  if (cnt == FULL_LAST) begin
                     cnt   <= '0;
                     b9    <= rx_i;
                     state <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == FULL_LAST) begin
                     cnt        <= '0;
                     frm_v_o    <= 1'b1;
                     frm_o.data <= sh;
                     frm_o.b9   <= nine_i ? b9 : rx_i;
                     frm_o.stop <= rx_i;
                     state      <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/afrx_match.sv
module afrx_match #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] rx_byte_i,
   input  logic [W-1:0] addr_i,
   input  logic [W-1:0] mask_i,
   output logic         ind_hit_o,
   output logic         bc_hit_o
);
   logic [W-1:0] ind_ok;
   logic [W-1:0] bc_ok;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign ind_ok[i] = !mask_i[i] || (rx_byte_i[i] == addr_i[i]);
         assign bc_ok[i]  = !(addr_i[i] || mask_i[i]) || rx_byte_i[i];
      end
   endgenerate

   assign ind_hit_o = &ind_ok;
   assign bc_hit_o  = &bc_ok;
endmodule

// File: rtl/addr_filter_uart_rx.sv
module addr_filter_uart_rx
   import afrx_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_i,
   input  logic              os_tick_i,
   input  logic [1:0]        mode_i,
   input  logic              filt_en_i,
   input  logic [BYTE_W-1:0] node_addr_i,
   input  logic [BYTE_W-1:0] node_mask_i,
   input  logic              flag_clr_i,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic              rx_bit9_o,
   output logic              rx_flag_o
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic      rx_s;
   logic      nine;
   logic      frm_v;
   rx_frame_t frm;
   logic      ind_hit;
   logic      bc_hit;
   logic      filt_on;
   logic      is_addr;
   logic      accept;

   assign nine = mode_i[1];

   afrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   afrx_deframer #(.OVS(OVS)) u_deframer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (os_tick_i),
      .rx_i   (rx_s),
      .nine_i (nine),
      .frm_o  (frm),
      .frm_v_o(frm_v)
   );

   afrx_match #(.W(BYTE_W)) u_match (
      .rx_byte_i(frm.data),
      .addr_i   (node_addr_i),
      .mask_i   (node_mask_i),
      .ind_hit_o(ind_hit),
      .bc_hit_o (bc_hit)
   );

   assign filt_on = filt_en_i && (mode_i != MODE_SHIFT);
   assign is_addr = nine ? frm.b9 : 1'b1;
   assign accept  = frm_v && frm.stop &&
                    (!filt_on || (is_addr && (ind_hit || bc_hit)));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rx_data_o <= '0;
         rx_bit9_o <= 1'b0;
         rx_flag_o <= 1'b0;
      end else begin
         if (frm_v) begin
            rx_data_o <= frm.data;
            rx_bit9_o <= frm.b9;
         end
         if (accept)          rx_flag_o <= 1'b1;
         else if (flag_clr_i) rx_flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/addr_filter_uart_rx_chk.sv
module addr_filter_uart_rx_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       flag_clr_i,
   input logic [1:0] mode_i,
   input logic       filt_en_i,
   input logic       frm_v,
   input logic       frm_stop,
   input logic       frm_b9,
   input logic [7:0] rx_data_o,
   input logic       rx_bit9_o,
   input logic       rx_flag_o
);
   // R4
   flag_needs_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rx_flag_o) |-> $past(frm_v && frm_stop));

   // R5
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_flag_o && !flag_clr_i) |=> rx_flag_o);

   // R5
   flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr_i && !frm_v) |=> !rx_flag_o);

   // R2
   data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frm_v |=> ($stable(rx_data_o) && $stable(rx_bit9_o)));

   // R6
   data_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_v && filt_en_i && mode_i[1] && !frm_b9 && !rx_flag_o) |=> !rx_flag_o);

   // R9
   shift_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_v && frm_stop && mode_i == 2'b00) |=> rx_flag_o);
endmodule

bind addr_filter_uart_rx addr_filter_uart_rx_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .flag_clr_i(flag_clr_i),
   .mode_i    (mode_i),
   .filt_en_i (filt_en_i),
   .frm_v     (frm_v),
   .frm_stop  (frm.stop),
   .frm_b9    (frm.b9),
   .rx_data_o (rx_data_o),
   .rx_bit9_o (rx_bit9_o),
   .rx_flag_o (rx_flag_o)
);

// File: tb/addr_filter_uart_rx_bench.sv
module addr_filter_uart_rx_bench;
   localparam int OVS     = 16;
   localparam int BIT_CLK = OVS * 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       tick = 1'b0;
   logic [1:0] mode = 2'd1;
   logic       filt = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] mask = 8'h00;
   logic       clr = 1'b0;
   logic [7:0] dout;
   logic       b9out;
   logic       flag;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   initial forever begin
      @(negedge clk);
      tick = ~tick;
   end

   addr_filter_uart_rx #(.OVS(OVS), .SYNC_STAGES(2)) u_addr_filter_uart_rx (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .rx_i       (rx),
      .os_tick_i  (tick),
      .mode_i     (mode),
      .filt_en_i  (filt),
      .node_addr_i(addr),
      .node_mask_i(mask),
      .flag_clr_i (clr),
      .rx_data_o  (dout),
      .rx_bit9_o  (b9out),
      .rx_flag_o  (flag)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v);
      @(negedge clk);
      rx = v;
      repeat (BIT_CLK - 1) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic has9, input logic n9, input logic stopv);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(d[i]);
      if (has9) drive_bit(n9);
      drive_bit(stopv);
      @(negedge clk);
      rx = 1'b1;
      repeat (BIT_CLK) @(negedge clk);
   endtask

   task automatic clear_flag();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 flag", {15'd0, flag}, 16'd0);
      check("R1 data", {8'd0, dout}, 16'd0);
      check("R1 bit9", {15'd0, b9out}, 16'd0);
   endtask

   task automatic t_plain_8bit();
      mode = 2'd1; filt = 1'b0;
      send(8'hA5, 1'b0, 1'b0, 1'b1);
      check("R2 data", {8'd0, dout}, 16'h00A5);
      check("R2 bit9 is stop", {15'd0, b9out}, 16'd1);
      check("R4 flag set", {15'd0, flag}, 16'd1);
      repeat (100) @(negedge clk);
      check("R5 sticky", {15'd0, flag}, 16'd1);
      clear_flag();
      check("R5 cleared", {15'd0, flag}, 16'd0);
   endtask

   task automatic t_plain_9bit();
      mode = 2'd3; filt = 1'b0;
      send(8'h3C, 1'b1, 1'b0, 1'b1);
      check("R4 9bit unfiltered flag", {15'd0, flag}, 16'd1);
      check("R2 9bit data", {8'd0, dout}, 16'h003C);
      check("R2 ninth bit", {15'd0, b9out}, 16'd0);
      clear_flag();
      mode = 2'd2;
      send(8'h3D, 1'b1, 1'b1, 1'b0);
      check("R4 bad stop no flag", {15'd0, flag}, 16'd0);
      check("R4 bad stop data", {8'd0, dout}, 16'h003D);
   endtask

   task automatic t_filter_9bit();
      mode = 2'd2; filt = 1'b1; addr = 8'hC0; mask = 8'hFD;
      clear_flag();
      send(8'hC2, 1'b1, 1'b1, 1'b1);
      check("R7 individual hit", {15'd0, flag}, 16'd1);
      clear_flag();
      send(8'hC1, 1'b1, 1'b1, 1'b1);
      check("R7 R8 miss no flag", {15'd0, flag}, 16'd0);
      check("R7 miss data latched", {8'd0, dout}, 16'h00C1);
      send(8'hC0, 1'b1, 1'b0, 1'b1);
      check("R6 data frame no flag", {15'd0, flag}, 16'd0);
      check("R6 data frame byte", {8'd0, dout}, 16'h00C0);
      check("R6 data frame ninth", {15'd0, b9out}, 16'd0);
      send(8'hFF, 1'b1, 1'b1, 1'b1);
      check("R8 broadcast hit", {15'd0, flag}, 16'd1);
      clear_flag();
   endtask

   task automatic t_filter_8bit();
      mode = 2'd1; filt = 1'b1; addr = 8'hC0; mask = 8'hFD;
      send(8'hC0, 1'b0, 1'b0, 1'b0);
      check("R11 bad stop no flag", {15'd0, flag}, 16'd0);
      send(8'h12, 1'b0, 1'b0, 1'b1);
      check("R11 mismatch no flag", {15'd0, flag}, 16'd0);
      send(8'hC0, 1'b0, 1'b0, 1'b1);
      check("R11 match flag", {15'd0, flag}, 16'd1);
      clear_flag();
   endtask

   task automatic t_shift_mode();
      mode = 2'd0; filt = 1'b1; addr = 8'hC0; mask = 8'hFD;
      send(8'h12, 1'b0, 1'b0, 1'b1);
      check("R9 shift ignores filter", {15'd0, flag}, 16'd1);
      check("R9 shift data", {8'd0, dout}, 16'h0012);
      clear_flag();
   endtask

   task automatic t_zero_regs();
      mode = 2'd3; filt = 1'b1; addr = 8'h00; mask = 8'h00;
      send(8'h5A, 1'b1, 1'b1, 1'b1);
      check("R10 zero regs match", {15'd0, flag}, 16'd1);
      clear_flag();
   endtask

   task automatic t_glitch();
      mode = 2'd1; filt = 1'b0;
      @(negedge clk);
      rx = 1'b0;
      repeat (4) @(negedge clk);
      rx = 1'b1;
      repeat (2 * BIT_CLK) @(negedge clk);
      check("R3 glitch no flag", {15'd0, flag}, 16'd0);
      check("R3 glitch data kept", {8'd0, dout}, 16'h005A);
      send(8'h81, 1'b0, 1'b0, 1'b1);
      check("R3 next frame data", {8'd0, dout}, 16'h0081);
      check("R3 next frame flag", {15'd0, flag}, 16'd1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_plain_8bit();
      t_plain_9bit();
      t_filter_9bit();
      t_filter_8bit();
      t_shift_mode();
      t_zero_regs();
      t_glitch();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule